// File: doc/BRIEF.md
# Table-Sequenced Radix-2 FFT Engine

This block computes an in-place radix-2 decimation-in-time FFT over complex samples with 16-bit I and Q parts. A single complex butterfly unit works through a working memory that holds the whole frame. The order in which operand pairs are visited is not built into the logic. A host first writes a sequence table in which every entry names one butterfly by its top address, its bottom address and its twiddle index. The engine then steps through that table from entry 0. Any valid radix-2 DIT schedule can therefore be used without changing the hardware.

The host writes the frame through the sample port, placing samples in bit-reversed order itself. It writes the sequence table, then pulses start with a length code between 5 and `LOG2_MAX`. The engine reports busy while it runs and pulses done when the last result is back in memory. The host then reads the natural-order spectrum through the read port. Each butterfly halves its outputs, so a full transform returns the DFT divided by N. Twiddle factors come from an internal quarter-wave cosine table sized for the largest transform. The default `LOG2_MAX` of 7 keeps elaboration small. A value of 12 gives the full range of 32 to 4096 points.

Top module: `fft_dit_seq`

## Requirements
- R1: While reset is asserted and right after it is released, busy_o, done_o and rd_data_o are all low.
- R2: While idle, a sample write stores ld_data_i (I in bits 31:16, Q in bits 15:0) at ld_addr_i. rd_data_o shows the word at rd_addr_i after one rising clock edge.
- R3: Each table entry updates its pair in place as top' = (A + W·B)/2 and bottom' = (A − W·B)/2, with truncation. W is exp(−j·2πk/NMAX) in Q1.15 with peak 32767. With bit-reversed input and a standard DIT table, the natural-order result equals the DFT divided by N to within a few LSB.
- R4: A table entry holds the twiddle index k in its low LOG2_MAX−1 bits, the bottom address in the next LOG2_MAX bits and the top address in the highest LOG2_MAX bits. Entries run in address order from 0. k may take any value from 0 to NMAX/2−1.
- R5: start_i while idle with length code L runs (2^L/2)·L entries. busy_o then stays high for exactly four cycles per entry.
- R6: done_o pulses for exactly one cycle, directly after the edge that writes back the final butterfly, in the same cycle that busy_o falls.
- R7: start_i while busy has no effect on the run in progress, its length, its timing or its result.
- R8: Sample writes and table writes that arrive while busy are dropped and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_we_i | input | 1 | Sample write strobe |
| ld_addr_i | input | LOG2_MAX | Sample write address |
| ld_data_i | input | 32 | Sample, I in 31:16, Q in 15:0 |
| tab_we_i | input | 1 | Sequence table write strobe |
| tab_addr_i | input | clog2((NMAX/2)·LOG2_MAX) | Sequence table entry address |
| tab_data_i | input | 3·LOG2_MAX−1 | Sequence table entry {top, bottom, twiddle} |
| start_i | input | 1 | Start a transform |
| len_log2_i | input | 4 | log2 of transform length, 5..LOG2_MAX |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_addr_i | input | LOG2_MAX | Result read address |
| rd_data_o | output | 32 | Registered read data, I in 31:16, Q in 15:0 |

## Verification
Host traffic on the sample, table and start ports can meet a running transform in the same cycle. The bench provokes this by writing a garbage sample to a live address, overwriting the last sequence table entry and raising start with a different length code, all in the middle of a run. The run counts as correct only if the cycle count from start to done is unchanged and every bin of the read-back spectrum matches the DFT of the undisturbed frame.

// File: rtl/fft_dit_pkg.sv
package fft_dit_pkg;
  localparam int DW = 16;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cplx_t;

  typedef enum logic [2:0] {ST_IDLE, ST_TAB, ST_RD, ST_MUL, ST_WB} seq_st_e;

  // Q1.15 cos(pi/2 * i/q), series evaluation at elaboration
  function automatic logic signed [DW-1:0] q15_cos(input int i, input int q);
    real x, t, s;
    x = 3.14159265358979 * real'(i) / (2.0 * real'(q));
    t = 1.0;
    s = 1.0;
    for (int n = 1; n <= 10; n++) begin
      t = -t * x * x / real'((2 * n - 1) * (2 * n));
      s = s + t;
    end
    s = s * 32767.0;
    return DW'($rtoi(s >= 0.0 ? s + 0.5 : s - 0.5));
  endfunction
endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom import fft_dit_pkg::*; #(
  parameter int LOG2_MAX = 7
) (
  input  logic [LOG2_MAX-2:0] idx_i,
  output cplx_t               w_o
);
  localparam int TW_AW = LOG2_MAX - 1;
  localparam int QTR   = 1 << (LOG2_MAX - 2);
  localparam logic [TW_AW-1:0] QTR_V = TW_AW'(QTR);

  logic signed [DW-1:0] cos_q [QTR+1];

  for (genvar g = 0; g <= QTR; g++) begin : g_qtab
    localparam logic signed [DW-1:0] CV = q15_cos(g, QTR);
    assign cos_q[g] = CV;
  end

  logic             lo_half;
  logic [TW_AW-1:0] m, c_ix, s_ix;

  always_comb begin
    lo_half = idx_i < QTR_V;
    m       = lo_half ? idx_i : idx_i - QTR_V;
    c_ix    = lo_half ? m : QTR_V - m;
    s_ix    = lo_half ? QTR_V - m : m;
    w_o.re  = lo_half ? cos_q[c_ix] : -cos_q[c_ix];
    w_o.im  = -cos_q[s_ix];
  end
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly import fft_dit_pkg::*; (
  input  cplx_t a_i,
  input  cplx_t b_i,
  input  cplx_t w_i,
  output cplx_t top_o,
  output cplx_t bot_o
);
  logic signed [2*DW-1:0] m_rr, m_ii, m_ri, m_ir;
  logic signed [2*DW:0]   pr, pi;
  logic signed [DW+1:0]   p_re, p_im, a_re, a_im, s_re, s_im, d_re, d_im;

  always_comb begin
    m_rr = b_i.re * w_i.re;
    m_ii = b_i.im * w_i.im;
    m_ri = b_i.re * w_i.im;
    m_ir = b_i.im * w_i.re;
    pr   = {m_rr[2*DW-1], m_rr} - {m_ii[2*DW-1], m_ii};
    pi   = {m_ri[2*DW-1], m_ri} + {m_ir[2*DW-1], m_ir};
    p_re = pr[2*DW:DW-1];
    p_im = pi[2*DW:DW-1];
    a_re = {{2{a_i.re[DW-1]}}, a_i.re};
    a_im = {{2{a_i.im[DW-1]}}, a_i.im};
    s_re = a_re + p_re;
    s_im = a_im + p_im;
    d_re = a_re - p_re;
    d_im = a_im - p_im;
    // halve each stage
    top_o.re = s_re[DW:1];
    top_o.im = s_im[DW:1];
    bot_o.re = d_re[DW:1];
    bot_o.im = d_im[DW:1];
  end
endmodule

// File: rtl/fft_dit_seq.sv
module fft_dit_seq import fft_dit_pkg::*; #(
  parameter int LOG2_MAX = 7
) (
  input  logic                                             clk_i,
  input  logic                                             rst_ni,
  input  logic                                             ld_we_i,
  input  logic [LOG2_MAX-1:0]                              ld_addr_i,
  input  logic [31:0]                                      ld_data_i,
  input  logic                                             tab_we_i,
  input  logic [$clog2((1<<(LOG2_MAX-1))*LOG2_MAX)-1:0]    tab_addr_i,
  input  logic [3*LOG2_MAX-2:0]                            tab_data_i,
  input  logic                                             start_i,
  input  logic [3:0]                                       len_log2_i,
  output logic                                             busy_o,
  output logic                                             done_o,
  input  logic [LOG2_MAX-1:0]                              rd_addr_i,
  output logic [31:0]                                      rd_data_o
);
  localparam int NMAX      = 1 << LOG2_MAX;
  localparam int AW        = LOG2_MAX;
  localparam int TW_AW     = LOG2_MAX - 1;
  localparam int TAB_DEPTH = (NMAX / 2) * LOG2_MAX;
  localparam int TAB_AW    = $clog2(TAB_DEPTH);
  localparam int ENT_W     = 2 * AW + TW_AW;
  localparam int LEN_MIN   = 5;

  seq_st_e           st_q;
  logic [TAB_AW-1:0] bf_idx_q, bf_last_q, bf_last_d;
  logic [ENT_W-1:0]  ent_q;
  logic              done_q;
  logic [31:0]       rd_q;
  cplx_t             a_q, b_q, w_q, ra_q, rb_q, w_d, top_d, bot_d;
  logic [ENT_W-1:0]  tab_mem [TAB_DEPTH];
  cplx_t             mem     [NMAX];

  logic [AW-1:0]     top_a, bot_a;
  logic [TW_AW-1:0]  tw_ix;
  logic              idle, accept, last_wb;

  assign idle    = st_q == ST_IDLE;
  assign accept  = idle && start_i;
  assign top_a   = ent_q[ENT_W-1 -: AW];
  assign bot_a   = ent_q[TW_AW +: AW];
  assign tw_ix   = ent_q[TW_AW-1:0];
  assign last_wb = st_q == ST_WB && bf_idx_q == bf_last_q;

  always_comb begin
    int len_c, tot;
    len_c = int'(len_log2_i);
    if (len_c < LEN_MIN) len_c = LEN_MIN;
    if (len_c > LOG2_MAX) len_c = LOG2_MAX;
    tot = (1 << (len_c - 1)) * len_c;
    bf_last_d = TAB_AW'(tot - 1);
  end

  fft_twiddle_rom #(.LOG2_MAX(LOG2_MAX)) tw_rom_i (
    .idx_i (tw_ix),
    .w_o   (w_d)
  );

  fft_butterfly bfly_i (
    .a_i   (a_q),
    .b_i   (b_q),
    .w_i   (w_q),
    .top_o (top_d),
    .bot_o (bot_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bf_idx_q  <= '0;
      bf_last_q <= '0;
      ent_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last_wb;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          bf_idx_q  <= '0;
          bf_last_q <= bf_last_d;
          st_q      <= ST_TAB;
        end
        ST_TAB: begin
          ent_q <= tab_mem[bf_idx_q];
          st_q  <= ST_RD;
        end
        ST_RD:  st_q <= ST_MUL;
        ST_MUL: st_q <= ST_WB;
        ST_WB: begin
          bf_idx_q <= bf_idx_q + 1'b1;
          st_q     <= last_wb ? ST_IDLE : ST_TAB;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk_i) begin
    if (st_q == ST_RD) begin
      a_q <= mem[top_a];
      b_q <= mem[bot_a];
      w_q <= w_d;
    end
    if (st_q == ST_MUL) begin
      ra_q <= top_d;
      rb_q <= bot_d;
    end
  end

  // write-back follows its own read by two cycles; host writes only when idle
  always_ff @(posedge clk_i) begin
    if (st_q == ST_WB) begin
      mem[top_a] <= ra_q;
      mem[bot_a] <= rb_q;
    end else if (idle && ld_we_i) begin
      mem[ld_addr_i] <= ld_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (idle && tab_we_i) tab_mem[tab_addr_i] <= tab_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem[rd_addr_i];
  end

  assign busy_o    = !idle;
  assign done_o    = done_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/fft_dit_seq_chk.sv
module fft_dit_seq_chk #(
  parameter int LOG2_MAX = 7
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [3:0] len_log2_i,
  input logic       busy_o,
  input logic       done_o
);
  int cyc_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= 0;
      exp_q <= 0;
    end else if (start_i && !busy_o) begin
      int l;
      l = int'(len_log2_i);
      if (l < 5) l = 5;
      if (l > LOG2_MAX) l = LOG2_MAX;
      cyc_q <= 0;
      exp_q <= 4 * (1 << (l - 1)) * l;
    end else if (busy_o) begin
      cyc_q <= cyc_q + 1;
    end
  end

  assert_start_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_run_cycles_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> cyc_q == exp_q);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !busy_o);

  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> busy_o || done_o);
endmodule

bind fft_dit_seq fft_dit_seq_chk #(.LOG2_MAX(LOG2_MAX)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .len_log2_i (len_log2_i),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/fft_dit_seq_tb_top.sv
`timescale 1ns/1ps
module fft_dit_seq_tb_top;
  localparam int LOG2_MAX  = 7;
  localparam int NMAX      = 1 << LOG2_MAX;
  localparam int AW        = LOG2_MAX;
  localparam int TW_AW     = LOG2_MAX - 1;
  localparam int TAB_DEPTH = (NMAX / 2) * LOG2_MAX;
  localparam int TAB_AW    = $clog2(TAB_DEPTH);
  localparam int ENT_W     = 2 * AW + TW_AW;
  localparam int TOL       = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ld_we_i = 1'b0;
  logic [AW-1:0]     ld_addr_i = '0;
  logic [31:0]       ld_data_i = '0;
  logic              tab_we_i = 1'b0;
  logic [TAB_AW-1:0] tab_addr_i = '0;
  logic [ENT_W-1:0]  tab_data_i = '0;
  logic              start_i = 1'b0;
  logic [3:0]        len_log2_i = 4'd5;
  logic              busy_o, done_o;
  logic [AW-1:0]     rd_addr_i = '0;
  logic [31:0]       rd_data_o;

  always #4 clk_i = ~clk_i;

  fft_dit_seq #(.LOG2_MAX(LOG2_MAX)) dut_i (.*);

  int n_checks = 0, n_fail = 0;
  int xr [NMAX];
  int xi [NMAX];
  int unsigned seed = 32'h1234_5678;

  typedef struct {int re; int im; int tol; string tag; int bin;} exp_t;
  exp_t exp_q[$];
  logic rd_req = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard as read data comes out
  always @(posedge clk_i) begin
    if (rd_req) begin
      #1;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected read data", 0, 1);
      end else begin
        exp_t e;
        int ar, ai, dr, di;
        e  = exp_q.pop_front();
        ar = int'($signed(rd_data_o[31:16]));
        ai = int'($signed(rd_data_o[15:0]));
        dr = ar > e.re ? ar - e.re : e.re - ar;
        di = ai > e.im ? ai - e.im : e.im - ai;
        n_checks++;
        if (dr > e.tol || di > e.tol) begin
          n_fail++;
          $display("FAIL %s bin %0d: actual (%0d,%0d) expected (%0d,%0d)",
                   e.tag, e.bin, ar, ai, e.re, e.im);
        end
      end
    end
  end

  function automatic int bitrev(input int v, input int bits);
    int r = 0;
    for (int b = 0; b < bits; b++) r |= ((v >> b) & 1) << (bits - 1 - b);
    return r;
  endfunction

  function automatic int rnd(input real v);
    return $rtoi($floor(v + 0.5));
  endfunction

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h1FFF) - 4096;
  endfunction

  task automatic load_samples(input int l);
    for (int n = 0; n < (1 << l); n++) begin
      @(negedge clk_i);
      ld_we_i   = 1'b1;
      ld_addr_i = AW'(bitrev(n, l));
      ld_data_i = {xr[n][15:0], xi[n][15:0]};
    end
    @(negedge clk_i);
    ld_we_i = 1'b0;
  endtask

  // R4: entry = {top, bottom, twiddle}
  task automatic load_table(input int l);
    int e = 0;
    int nn = 1 << l;
    for (int s = 1; s <= l; s++) begin
      int half = 1 << (s - 1);
      int span = half * 2;
      for (int g = 0; g < nn; g += span) begin
        for (int j = 0; j < half; j++) begin
          @(negedge clk_i);
          tab_we_i   = 1'b1;
          tab_addr_i = TAB_AW'(e);
          tab_data_i = {AW'(g + j), AW'(g + j + half), TW_AW'(j * (NMAX / span))};
          e++;
        end
      end
    end
    @(negedge clk_i);
    tab_we_i = 1'b0;
  endtask

  task automatic push_dft(input int l, input string tag);
    int nn = 1 << l;
    for (int k = 0; k < nn; k++) begin
      real sr = 0.0, si = 0.0;
      exp_t e;
      for (int n = 0; n < nn; n++) begin
        real th = 2.0 * 3.14159265358979 * real'((k * n) % nn) / real'(nn);
        sr += real'(xr[n]) * $cos(th) + real'(xi[n]) * $sin(th);
        si += real'(xi[n]) * $cos(th) - real'(xr[n]) * $sin(th);
      end
      e.re = rnd(sr / real'(nn)); e.im = rnd(si / real'(nn));
      e.tol = TOL; e.tag = tag; e.bin = k;
      exp_q.push_back(e);
    end
  endtask

  task automatic read_out(input int nn);
    for (int k = 0; k < nn; k++) begin
      @(negedge clk_i);
      rd_addr_i = AW'(k);
      rd_req    = 1'b1;
    end
    @(negedge clk_i);
    rd_req = 1'b0;
    @(negedge clk_i);
    check(exp_q.size() == 0, "R2", "scoreboard left over", exp_q.size(), 0);
  endtask

  // runs one transform; disturb injects host traffic mid-run (R7, R8)
  task automatic run(input int l, input bit disturb, input string tag);
    int cyc = 0;
    int tot = (1 << (l - 1)) * l;
    @(negedge clk_i);
    start_i    = 1'b1;
    len_log2_i = 4'(l);
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R5", "busy after start", int'(busy_o), 1);
    while (1) begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      if (done_o) break;
      if (disturb && cyc == 10) begin
        start_i    = 1'b1;
        len_log2_i = 4'(l == 5 ? 7 : 5);
        ld_we_i    = 1'b1;
        ld_addr_i  = AW'(1);
        ld_data_i  = 32'h7FFF_8001;
        tab_we_i   = 1'b1;
        tab_addr_i = TAB_AW'(tot - 1);
        tab_data_i = '1;
      end else if (disturb && cyc == 11) begin
        start_i  = 1'b0;
        ld_we_i  = 1'b0;
        tab_we_i = 1'b0;
      end
      if (cyc > 60000) break;
    end
    check(cyc == 4 * tot, tag, "cycles start to done", cyc, 4 * tot);
    check(busy_o == 1'b0, "R6", "busy low with done", int'(busy_o), 0);
    @(negedge clk_i);
    check(done_o == 1'b0, "R6", "done one cycle", int'(done_o), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++;
    n_checks++;
    $display("FAIL R5 watchdog expired: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(busy_o == 1'b0, "R1", "busy in reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    check(rd_data_o == 32'd0, "R1", "read data in reset", int'(rd_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset",
          int'({busy_o, done_o}), 0);

    // impulse, also raw read-back of the loaded frame
    for (int n = 0; n < NMAX; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 16000; xi[0] = -3200; xr[5] = 1000;
    load_samples(5);
    for (int a = 0; a < 32; a++) begin
      exp_t e;
      e.re = xr[bitrev(a, 5)]; e.im = xi[bitrev(a, 5)];
      e.tol = 0; e.tag = "R2"; e.bin = a;
      exp_q.push_back(e);
    end
    read_out(32);
    load_table(5);
    run(5, 1'b0, "R5");
    push_dft(5, "R3");
    read_out(32);

    // complex tone at bin 3
    for (int n = 0; n < 32; n++) begin
      real th = 2.0 * 3.14159265358979 * 3.0 * real'(n) / 32.0;
      xr[n] = rnd(8000.0 * $cos(th));
      xi[n] = rnd(8000.0 * $sin(th));
    end
    load_samples(5);
    run(5, 1'b0, "R5");
    push_dft(5, "R3");
    read_out(32);

    // random frames at the larger sizes, full twiddle range
    for (int n = 0; n < 64; n++) begin xr[n] = next_rand(); xi[n] = next_rand(); end
    load_samples(6);
    load_table(6);
    run(6, 1'b0, "R5");
    push_dft(6, "R4");
    read_out(64);

    for (int n = 0; n < 128; n++) begin xr[n] = next_rand(); xi[n] = next_rand(); end
    load_samples(7);
    load_table(7);
    run(7, 1'b0, "R5");
    push_dft(7, "R4");
    read_out(128);

    // host traffic collides with a running transform
    for (int n = 0; n < 32; n++) begin xr[n] = next_rand(); xi[n] = next_rand(); end
    load_samples(5);
    load_table(5);
    run(5, 1'b1, "R7");
    push_dft(5, "R8");
    read_out(32);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule